// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block predicts which earlier store a load or store should wait for in an out-of-order core. Instructions that have collided in memory before are grouped into a "store set". A PC-indexed identifier table maps each instruction to a set number. A per-set table records the sequence number of the most recently dispatched store of that set, together with a count of how many stores belong to the set.

Training happens when the core detects an ordering violation between a store and a load. Dispatching stores records their sequence numbers. Issuing stores retire their own record. A squash removes records of younger, squashed stores. At dispatch the core asks for a dependence with a combinational lookup. The lookup returns the sequence number to wait on, or 0 for none. Sequence number 0 is never given to a real store. A global clear forgets all mappings and keeps the set counters.

Top module: `ssp_predictor`

## Requirements
- R1: The identifier-table slot of a PC is (PC >> 2) modulo SSIT_N. A fresh set number is (load PC >> 2) modulo LFST_N. Both sizes are powers of two, so PCs that differ by a multiple of 4*SSIT_N share a slot.
- R2: Training with neither slot valid writes the fresh set number into the load slot and the store slot, marks both valid and adds one to that set's counter.
- R3: Training with only the load slot valid gives the store slot the load's set and adds one to that set's counter.
- R4: Training with only the store slot valid gives the load slot the store's set and leaves all counters unchanged.
- R5: Training with both slots valid in different sets works as follows. If the load's set counter is strictly larger, the store moves into the load's set. Otherwise, ties included, the load moves into the store's set. The gaining set's counter goes up by one and the losing set's counter goes down by one. Counters saturate at 0 and at their maximum. A counter changes by at most one per cycle.
- R6: Dispatching a store whose slot is valid writes its sequence number into its set's record and marks the record valid. Dispatching a load, or a store with an invalid slot, changes nothing.
- R7: The lookup returns 0 when the PC's slot or its set's record is invalid, and otherwise returns the recorded sequence number. It is combinational and reflects the table state from the start of the cycle.
- R8: A store issue clears its set's record only when the slot is valid and the record holds exactly that store's sequence number. A load issue, or a store issue with a different sequence number, has no effect.
- R9: A squash invalidates, in one cycle, every valid record whose sequence number is greater than the squash sequence number, and keeps the others.
- R10: Clear invalidates every slot and every record and keeps the set counters.
- R11: Only one operation takes effect per cycle, chosen in this order: clear, squash, training, store issue, store dispatch. Lower-ranked requests in that cycle are dropped.
- R12: After reset all slots and records are invalid and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Global clear of valid bits |
| sq_valid_i | input | 1 | Squash request |
| sq_seq_i | input | SEQ_W | Squash sequence number |
| trn_valid_i | input | 1 | Violation training request |
| trn_store_pc_i | input | PC_W | PC of the violating store |
| trn_load_pc_i | input | PC_W | PC of the violating load |
| iss_valid_i | input | 1 | Issue notification |
| iss_is_store_i | input | 1 | Issued instruction is a store |
| iss_pc_i | input | PC_W | PC of issued instruction |
| iss_seq_i | input | SEQ_W | Sequence number of issued instruction |
| dsp_valid_i | input | 1 | Dispatch notification |
| dsp_is_store_i | input | 1 | Dispatched instruction is a store |
| dsp_pc_i | input | PC_W | PC of dispatched instruction |
| dsp_seq_i | input | SEQ_W | Sequence number of dispatched instruction |
| lkp_pc_i | input | PC_W | Lookup PC |
| lkp_dep_seq_o | output | SEQ_W | Predicted dependence sequence number, 0 for none |

## Verification
Training is exercised with all four validity combinations of the load and store slots. The merge case is driven once with the load's set larger, once with equal counters and once with counters already at zero, so lookups show which set absorbed which instruction. Aliased PCs separate correct slot masking from full-PC matching. Issues with matching and non-matching sequence numbers, and squashes that fall between two recorded stores, show that invalidation is exact. Same-cycle requests of several kinds, and a clear followed by retraining, show the priority order and that counters persist across a clear.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int unsigned PC_OFS = 2;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CLEAR,
        OP_SQUASH,
        OP_TRAIN,
        OP_ISSUE,
        OP_DISPATCH
    } ssp_op_e;

    // Word-aligned PC folded into a power-of-two table.
    function automatic logic [31:0] pc_slot(input logic [63:0] pc, input logic [31:0] mask);
        return 32'(pc >> PC_OFS) & mask;
    endfunction

endpackage

// File: rtl/ssp_op_arb.sv
module ssp_op_arb
    import ssp_pkg::*;
(
    input  logic    clr_i,
    input  logic    sq_i,
    input  logic    trn_i,
    input  logic    iss_st_i,
    input  logic    dsp_st_i,
    output ssp_op_e op_o
);
    always_comb begin
        if (clr_i)         op_o = OP_CLEAR;
        else if (sq_i)     op_o = OP_SQUASH;
        else if (trn_i)    op_o = OP_TRAIN;
        else if (iss_st_i) op_o = OP_ISSUE;
        else if (dsp_st_i) op_o = OP_DISPATCH;
        else               op_o = OP_IDLE;
    end

    // R11: a clear request always wins the cycle
    always_comb a_r11_clear_first: assert (!clr_i || op_o == OP_CLEAR);
endmodule

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
    parameter int N     = 64,
    parameter int ID_W  = 4,
    parameter int NRD   = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr_i,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx_i,
    output logic [NRD-1:0]             rd_vld_o,
    output logic [NRD-1:0][ID_W-1:0]   rd_id_o,
    input  logic [1:0]                 wr_en_i,
    input  logic [1:0][IDX_W-1:0]      wr_idx_i,
    input  logic [1:0][ID_W-1:0]       wr_id_i
);
    logic [N-1:0]    vld_q;
    logic [ID_W-1:0] id_q [N];

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_vld_o[r] = vld_q[rd_idx_i[r]];
        assign rd_id_o[r]  = id_q[rd_idx_i[r]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < N; i++) id_q[i] <= '0;
        end else if (clr_i) begin
            vld_q <= '0;
        end else begin
            for (int w = 0; w < 2; w++) begin
                if (wr_en_i[w]) begin
                    vld_q[wr_idx_i[w]] <= 1'b1;
                    id_q[wr_idx_i[w]]  <= wr_id_i[w];
                end
            end
        end
    end

    // R10: clear empties every slot
    a_r10_slots_cleared: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> vld_q == '0);
    // R2: a trained store slot becomes valid
    a_r2_store_slot_valid: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i[1] && !clr_i) |=> vld_q[$past(wr_idx_i[1])]);
    // R3: the written set number is held in the slot
    a_r3_slot_holds_id: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i[1] && !clr_i) |=> id_q[$past(wr_idx_i[1])] == $past(wr_id_i[1]));
endmodule

// File: rtl/ssp_set_table.sv
module ssp_set_table
    import ssp_pkg::*;
#(
    parameter int N     = 16,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 4,
    parameter int ID_W  = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  ssp_op_e          op_i,
    input  logic [SEQ_W-1:0] sq_seq_i,
    input  logic             st_vld_i,
    input  logic [ID_W-1:0]  st_id_i,
    input  logic [SEQ_W-1:0] st_seq_i,
    input  logic [ID_W-1:0]  lk_id_i,
    output logic             lk_hit_o,
    output logic [SEQ_W-1:0] lk_seq_o,
    input  logic [ID_W-1:0]  ca_id_i,
    input  logic [ID_W-1:0]  cb_id_i,
    output logic [CNT_W-1:0] ca_cnt_o,
    output logic [CNT_W-1:0] cb_cnt_o,
    input  logic             inc_en_i,
    input  logic [ID_W-1:0]  inc_id_i,
    input  logic             dec_en_i,
    input  logic [ID_W-1:0]  dec_id_i
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [N-1:0]            vld_q;
    logic [N-1:0][SEQ_W-1:0] seq_q;
    logic [N-1:0][CNT_W-1:0] cnt_q;
    logic                    self_hit;

    assign lk_hit_o = vld_q[lk_id_i];
    assign lk_seq_o = seq_q[lk_id_i];
    assign ca_cnt_o = cnt_q[ca_id_i];
    assign cb_cnt_o = cnt_q[cb_id_i];
    assign self_hit = st_vld_i && vld_q[st_id_i] && (seq_q[st_id_i] == st_seq_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            seq_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (op_i)
                OP_CLEAR: vld_q <= '0;
                OP_SQUASH: begin
                    for (int i = 0; i < N; i++)
                        if (seq_q[i] > sq_seq_i) vld_q[i] <= 1'b0;
                end
                OP_TRAIN: begin
                    for (int i = 0; i < N; i++) begin
                        if (inc_en_i && inc_id_i == ID_W'(i) && cnt_q[i] != CNT_MAX)
                            cnt_q[i] <= cnt_q[i] + 1'b1;
                        else if (dec_en_i && dec_id_i == ID_W'(i) && cnt_q[i] != '0)
                            cnt_q[i] <= cnt_q[i] - 1'b1;
                    end
                end
                OP_ISSUE: begin
                    if (self_hit) vld_q[st_id_i] <= 1'b0;
                end
                OP_DISPATCH: begin
                    if (st_vld_i) begin
                        vld_q[st_id_i] <= 1'b1;
                        seq_q[st_id_i] <= st_seq_i;
                    end
                end
                default: ;
            endcase
        end
    end

    // R10: clear empties the records but keeps counters
    a_r10_records_cleared: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_CLEAR |=> vld_q == '0);
    a_r10_counters_kept: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_CLEAR |=> $stable(cnt_q));
    // R8: an issuing store retires its own record
    a_r8_self_retire: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ISSUE && self_hit) |=> !vld_q[$past(st_id_i)]);
    // R6: a mapped store dispatch leaves a valid record
    a_r6_dispatch_records: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_DISPATCH && st_vld_i) |=> vld_q[$past(st_id_i)]);

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R9: younger records vanish on squash
        a_r9_squash_younger: assert property (@(posedge clk) disable iff (rst)
            (op_i == OP_SQUASH && seq_q[g] > sq_seq_i) |=> !vld_q[g]);
        // R5: counters move by at most one per cycle
        a_r5_cnt_step: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (cnt_q[g] == $past(cnt_q[g]) ||
                      cnt_q[g] == $past(cnt_q[g]) + 1'b1 ||
                      cnt_q[g] == $past(cnt_q[g]) - 1'b1));
    end
endmodule

// File: rtl/ssp_trainer.sv
module ssp_trainer
    import ssp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int N_SET = 16,
    parameter int CNT_W = 4,
    parameter int ID_W  = $clog2(N_SET)
) (
    input  logic               en_i,
    input  logic [PC_W-1:0]    load_pc_i,
    input  logic               l_vld_i,
    input  logic [ID_W-1:0]    l_id_i,
    input  logic               s_vld_i,
    input  logic [ID_W-1:0]    s_id_i,
    input  logic [CNT_W-1:0]   l_cnt_i,
    input  logic [CNT_W-1:0]   s_cnt_i,
    output logic [1:0]         wr_en_o,
    output logic [1:0][ID_W-1:0] wr_id_o,
    output logic               inc_en_o,
    output logic [ID_W-1:0]    inc_id_o,
    output logic               dec_en_o,
    output logic [ID_W-1:0]    dec_id_o
);
    logic [ID_W-1:0] fresh_id;
    assign fresh_id = ID_W'(pc_slot(64'(load_pc_i), 32'(N_SET - 1)));

    // index 0 = load slot, index 1 = store slot
    always_comb begin
        wr_en_o  = '0;
        wr_id_o  = '0;
        inc_en_o = 1'b0;
        inc_id_o = '0;
        dec_en_o = 1'b0;
        dec_id_o = '0;
        if (en_i) begin
            unique case ({l_vld_i, s_vld_i})
                2'b00: begin
                    wr_en_o  = 2'b11;
                    wr_id_o  = {fresh_id, fresh_id};
                    inc_en_o = 1'b1;
                    inc_id_o = fresh_id;
                end
                2'b10: begin
                    wr_en_o[1] = 1'b1;
                    wr_id_o[1] = l_id_i;
                    inc_en_o   = 1'b1;
                    inc_id_o   = l_id_i;
                end
                2'b01: begin
                    wr_en_o[0] = 1'b1;
                    wr_id_o[0] = s_id_i;
                end
                default: begin
                    if (l_id_i != s_id_i) begin
                        inc_en_o = 1'b1;
                        dec_en_o = 1'b1;
                        if (l_cnt_i > s_cnt_i) begin
                            wr_en_o[1] = 1'b1;
                            wr_id_o[1] = l_id_i;
                            inc_id_o   = l_id_i;
                            dec_id_o   = s_id_i;
                        end else begin
                            wr_en_o[0] = 1'b1;
                            wr_id_o[0] = s_id_i;
                            inc_id_o   = s_id_i;
                            dec_id_o   = l_id_i;
                        end
                    end
                end
            endcase
        end
    end

    // R4: a load joining a store's set never grows a counter
    always_comb a_r4_load_no_grow: assert (!(en_i && !l_vld_i && s_vld_i) || !inc_en_o);
    // R5: winner and loser are always distinct sets
    always_comb a_r5_distinct_sets: assert (!(inc_en_o && dec_en_o) || inc_id_o != dec_id_o);
endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor
    import ssp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int SEQ_W  = 16,
    parameter int SSIT_N = 64,
    parameter int LFST_N = 16,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             sq_valid_i,
    input  logic [SEQ_W-1:0] sq_seq_i,
    input  logic             trn_valid_i,
    input  logic [PC_W-1:0]  trn_store_pc_i,
    input  logic [PC_W-1:0]  trn_load_pc_i,
    input  logic             iss_valid_i,
    input  logic             iss_is_store_i,
    input  logic [PC_W-1:0]  iss_pc_i,
    input  logic [SEQ_W-1:0] iss_seq_i,
    input  logic             dsp_valid_i,
    input  logic             dsp_is_store_i,
    input  logic [PC_W-1:0]  dsp_pc_i,
    input  logic [SEQ_W-1:0] dsp_seq_i,
    input  logic [PC_W-1:0]  lkp_pc_i,
    output logic [SEQ_W-1:0] lkp_dep_seq_o
);
    localparam int IDX_W = $clog2(SSIT_N);
    localparam int ID_W  = $clog2(LFST_N);
    localparam int NRD   = 4;
    localparam int RD_LK = 0, RD_LD = 1, RD_ST = 2, RD_OP = 3;

    ssp_op_e                    op;
    logic [PC_W-1:0]            op_pc;
    logic [SEQ_W-1:0]           op_seq;
    logic [NRD-1:0][IDX_W-1:0]  rd_idx;
    logic [NRD-1:0]             rd_vld;
    logic [NRD-1:0][ID_W-1:0]   rd_id;
    logic [1:0]                 wr_en;
    logic [1:0][IDX_W-1:0]      wr_idx;
    logic [1:0][ID_W-1:0]       wr_id;
    logic                       inc_en, dec_en;
    logic [ID_W-1:0]            inc_id, dec_id;
    logic [CNT_W-1:0]           l_cnt, s_cnt;
    logic                       lk_hit;
    logic [SEQ_W-1:0]           lk_seq;

    ssp_op_arb u_arb (
        .clr_i    (clr_i),
        .sq_i     (sq_valid_i),
        .trn_i    (trn_valid_i),
        .iss_st_i (iss_valid_i && iss_is_store_i),
        .dsp_st_i (dsp_valid_i && dsp_is_store_i),
        .op_o     (op)
    );

    assign op_pc  = (op == OP_ISSUE) ? iss_pc_i  : dsp_pc_i;
    assign op_seq = (op == OP_ISSUE) ? iss_seq_i : dsp_seq_i;

    assign rd_idx[RD_LK] = IDX_W'(pc_slot(64'(lkp_pc_i),       32'(SSIT_N - 1)));
    assign rd_idx[RD_LD] = IDX_W'(pc_slot(64'(trn_load_pc_i),  32'(SSIT_N - 1)));
    assign rd_idx[RD_ST] = IDX_W'(pc_slot(64'(trn_store_pc_i), 32'(SSIT_N - 1)));
    assign rd_idx[RD_OP] = IDX_W'(pc_slot(64'(op_pc),          32'(SSIT_N - 1)));
    assign wr_idx        = {rd_idx[RD_ST], rd_idx[RD_LD]};

    ssp_id_table #(.N(SSIT_N), .ID_W(ID_W), .NRD(NRD), .IDX_W(IDX_W)) u_ssit (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (op == OP_CLEAR),
        .rd_idx_i (rd_idx),
        .rd_vld_o (rd_vld),
        .rd_id_o  (rd_id),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_id_i  (wr_id)
    );

    ssp_trainer #(.PC_W(PC_W), .N_SET(LFST_N), .CNT_W(CNT_W), .ID_W(ID_W)) u_trn (
        .en_i      (op == OP_TRAIN),
        .load_pc_i (trn_load_pc_i),
        .l_vld_i   (rd_vld[RD_LD]),
        .l_id_i    (rd_id[RD_LD]),
        .s_vld_i   (rd_vld[RD_ST]),
        .s_id_i    (rd_id[RD_ST]),
        .l_cnt_i   (l_cnt),
        .s_cnt_i   (s_cnt),
        .wr_en_o   (wr_en),
        .wr_id_o   (wr_id),
        .inc_en_o  (inc_en),
        .inc_id_o  (inc_id),
        .dec_en_o  (dec_en),
        .dec_id_o  (dec_id)
    );

    ssp_set_table #(.N(LFST_N), .SEQ_W(SEQ_W), .CNT_W(CNT_W), .ID_W(ID_W)) u_lfst (
        .clk      (clk),
        .rst      (rst),
        .op_i     (op),
        .sq_seq_i (sq_seq_i),
        .st_vld_i (rd_vld[RD_OP]),
        .st_id_i  (rd_id[RD_OP]),
        .st_seq_i (op_seq),
        .lk_id_i  (rd_id[RD_LK]),
        .lk_hit_o (lk_hit),
        .lk_seq_o (lk_seq),
        .ca_id_i  (rd_id[RD_LD]),
        .cb_id_i  (rd_id[RD_ST]),
        .ca_cnt_o (l_cnt),
        .cb_cnt_o (s_cnt),
        .inc_en_i (inc_en),
        .inc_id_i (inc_id),
        .dec_en_i (dec_en),
        .dec_id_i (dec_id)
    );

    assign lkp_dep_seq_o = (rd_vld[RD_LK] && lk_hit) ? lk_seq : '0;

    // R7: after a clear no lookup reports a dependence
    a_r7_clear_no_dep: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> lkp_dep_seq_o == '0);
    // R11: squash outranks dispatch, so no record is written that cycle
    a_r11_squash_over_dispatch: assert property (@(posedge clk) disable iff (rst)
        (sq_valid_i && !clr_i) |-> op == OP_SQUASH);
endmodule

// File: tb/sim_ssp_predictor.sv
module sim_ssp_predictor;
    localparam int SSIT_N = 64;
    localparam int LFST_N = 16;
    localparam int CMAX   = 15;

    logic        clk = 1'b0;
    logic        rst;
    logic        clr, sq_v, trn_v, iss_v, iss_st, dsp_v, dsp_st;
    logic [15:0] sq_seq, iss_seq, dsp_seq;
    logic [31:0] trn_spc, trn_lpc, iss_pc, dsp_pc, lkp_pc;
    logic [15:0] dep;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    bit m_sv [SSIT_N];
    int m_sid[SSIT_N];
    bit m_lv [LFST_N];
    int m_lseq[LFST_N];
    int m_cnt[LFST_N];

    always #5 clk = ~clk;

    ssp_predictor u0 (
        .clk(clk), .rst(rst), .clr_i(clr),
        .sq_valid_i(sq_v), .sq_seq_i(sq_seq),
        .trn_valid_i(trn_v), .trn_store_pc_i(trn_spc), .trn_load_pc_i(trn_lpc),
        .iss_valid_i(iss_v), .iss_is_store_i(iss_st), .iss_pc_i(iss_pc), .iss_seq_i(iss_seq),
        .dsp_valid_i(dsp_v), .dsp_is_store_i(dsp_st), .dsp_pc_i(dsp_pc), .dsp_seq_i(dsp_seq),
        .lkp_pc_i(lkp_pc), .lkp_dep_seq_o(dep)
    );

    function automatic int slot(input logic [31:0] pc);
        return int'((pc >> 2) % SSIT_N);
    endfunction

    function automatic int m_lookup(input logic [31:0] pc);
        int s = slot(pc);
        if (!m_sv[s]) return 0;
        if (!m_lv[m_sid[s]]) return 0;
        return m_lseq[m_sid[s]];
    endfunction

    task automatic m_reset();
        foreach (m_sv[i]) begin m_sv[i] = 0; m_sid[i] = 0; end
        foreach (m_lv[i]) begin m_lv[i] = 0; m_lseq[i] = 0; m_cnt[i] = 0; end
    endtask

    task automatic m_inc(input int k);
        if (m_cnt[k] < CMAX) m_cnt[k]++;
    endtask

    task automatic m_dec(input int k);
        if (m_cnt[k] > 0) m_cnt[k]--;
    endtask

    task automatic m_step();
        if (clr) begin
            foreach (m_sv[i]) m_sv[i] = 0;
            foreach (m_lv[i]) m_lv[i] = 0;
        end else if (sq_v) begin
            foreach (m_lv[i]) if (m_lv[i] && m_lseq[i] > int'(sq_seq)) m_lv[i] = 0;
        end else if (trn_v) begin
            int ls = slot(trn_lpc);
            int ss = slot(trn_spc);
            if (!m_sv[ls] && !m_sv[ss]) begin
                int f = int'((trn_lpc >> 2) % LFST_N);
                m_sv[ls] = 1; m_sid[ls] = f;
                m_sv[ss] = 1; m_sid[ss] = f;
                m_inc(f);
            end else if (m_sv[ls] && !m_sv[ss]) begin
                m_sv[ss] = 1; m_sid[ss] = m_sid[ls];
                m_inc(m_sid[ls]);
            end else if (!m_sv[ls] && m_sv[ss]) begin
                m_sv[ls] = 1; m_sid[ls] = m_sid[ss];
            end else if (m_sid[ls] != m_sid[ss]) begin
                int a = m_sid[ls];
                int b = m_sid[ss];
                if (m_cnt[a] > m_cnt[b]) begin
                    m_sid[ss] = a; m_inc(a); m_dec(b);
                end else begin
                    m_sid[ls] = b; m_inc(b); m_dec(a);
                end
            end
        end else if (iss_v && iss_st) begin
            int s = slot(iss_pc);
            if (m_sv[s] && m_lv[m_sid[s]] && m_lseq[m_sid[s]] == int'(iss_seq))
                m_lv[m_sid[s]] = 0;
        end else if (dsp_v && dsp_st) begin
            int s = slot(dsp_pc);
            if (m_sv[s]) begin
                m_lv[m_sid[s]] = 1;
                m_lseq[m_sid[s]] = int'(dsp_seq);
            end
        end
    endtask

    task automatic idle();
        clr = 0; sq_v = 0; trn_v = 0; iss_v = 0; iss_st = 0; dsp_v = 0; dsp_st = 0;
        sq_seq = 0; iss_seq = 0; dsp_seq = 0;
        trn_spc = 0; trn_lpc = 0; iss_pc = 0; dsp_pc = 0;
    endtask

    // inputs are set just after a falling edge; compare, then advance one cycle
    task automatic tick(input string tag);
        int exp;
        #2;
        exp = m_lookup(lkp_pc);
        n_cmp++;
        if (int'(dep) != exp) begin
            n_bad++;
            $display("FAIL %s: lookup pc=%h got %0d expected %0d", tag, lkp_pc, dep, exp);
        end
        @(posedge clk);
        if (!rst) m_step();
        @(negedge clk);
        idle();
    endtask

    task automatic look(input logic [31:0] pc, input string tag);
        lkp_pc = pc;
        tick(tag);
    endtask

    task automatic train(input logic [31:0] spc, input logic [31:0] lpc, input string tag);
        trn_v = 1; trn_spc = spc; trn_lpc = lpc;
        tick(tag);
    endtask

    task automatic disp(input logic [31:0] pc, input int seq, input bit st, input string tag);
        dsp_v = 1; dsp_st = st; dsp_pc = pc; dsp_seq = 16'(seq);
        tick(tag);
    endtask

    task automatic issue(input logic [31:0] pc, input int seq, input bit st, input string tag);
        iss_v = 1; iss_st = st; iss_pc = pc; iss_seq = 16'(seq);
        tick(tag);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle();
        lkp_pc = 0;
        m_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        // R12: empty after reset
        look(32'h10, "R12");
        look(32'h14, "R12");

        // R2: fresh set from load PC 0x14 -> set 5
        train(32'h10, 32'h14, "R2");
        disp(32'h10, 10, 1, "R6");
        look(32'h14, "R2");
        look(32'h10, "R7");
        // R1: alias of the store slot (0x10 + 4*64)
        look(32'h110, "R1");
        look(32'h40, "R1");
        // R6: load dispatch and unmapped store dispatch change nothing
        disp(32'h14, 11, 0, "R6");
        look(32'h14, "R6");
        disp(32'h40, 12, 1, "R6");
        look(32'h40, "R6");
        look(32'h14, "R6");
        // R7: same-cycle dispatch is not seen by the lookup
        lkp_pc = 32'h14;
        dsp_v = 1; dsp_st = 1; dsp_pc = 32'h10; dsp_seq = 13;
        tick("R7");
        look(32'h14, "R7");
        // R8: mismatching issue, load issue, then exact issue
        issue(32'h10, 99, 1, "R8");
        look(32'h14, "R8");
        issue(32'h10, 13, 0, "R8");
        look(32'h14, "R8");
        issue(32'h10, 13, 1, "R8");
        look(32'h14, "R8");

        // R3: store joins the load's set
        train(32'h18, 32'h14, "R3");
        disp(32'h18, 20, 1, "R3");
        look(32'h14, "R3");
        // R4: load joins the store's set
        train(32'h10, 32'h1C, "R4");
        look(32'h1C, "R4");

        // R5: load's set larger -> store moves
        train(32'h20, 32'h24, "R5");
        train(32'h20, 32'h14, "R5");
        disp(32'h20, 30, 1, "R5");
        look(32'h14, "R5");
        look(32'h24, "R5");
        // R5: tie -> load moves into store's set
        train(32'h28, 32'h2C, "R5");
        train(32'h30, 32'h34, "R5");
        train(32'h30, 32'h2C, "R5");
        disp(32'h30, 40, 1, "R5");
        look(32'h2C, "R5");
        disp(32'h28, 41, 1, "R5");
        look(32'h2C, "R5");
        // R5: counters at zero saturate
        train(32'h28, 32'h24, "R5");
        disp(32'h28, 42, 1, "R5");
        look(32'h24, "R5");
        train(32'h30, 32'h14, "R5");
        disp(32'h30, 43, 1, "R5");
        look(32'h14, "R5");
        look(32'h34, "R5");

        // R9: squash between two records
        disp(32'h10, 50, 1, "R9");
        disp(32'h28, 60, 1, "R9");
        look(32'h14, "R9");
        sq_v = 1; sq_seq = 55;
        tick("R9");
        look(32'h14, "R9");
        look(32'h24, "R9");

        // R11: squash beats dispatch
        sq_v = 1; sq_seq = 200; dsp_v = 1; dsp_st = 1; dsp_pc = 32'h28; dsp_seq = 70;
        tick("R11");
        look(32'h24, "R11");
        // R11: training beats dispatch
        trn_v = 1; trn_spc = 32'h50; trn_lpc = 32'h54; dsp_v = 1; dsp_st = 1; dsp_pc = 32'h28; dsp_seq = 71;
        tick("R11");
        look(32'h24, "R11");
        // R11: issue beats dispatch, load issue does not block dispatch
        disp(32'h28, 72, 1, "R11");
        iss_v = 1; iss_st = 1; iss_pc = 32'h28; iss_seq = 72; dsp_v = 1; dsp_st = 1; dsp_pc = 32'h28; dsp_seq = 73;
        tick("R11");
        look(32'h24, "R11");
        iss_v = 1; iss_st = 0; iss_pc = 32'h28; iss_seq = 0; dsp_v = 1; dsp_st = 1; dsp_pc = 32'h28; dsp_seq = 74;
        tick("R11");
        look(32'h24, "R11");
        // R11: clear beats everything
        disp(32'h10, 80, 1, "R11");
        clr = 1; sq_v = 1; sq_seq = 1; trn_v = 1; trn_spc = 32'h60; trn_lpc = 32'h64;
        dsp_v = 1; dsp_st = 1; dsp_pc = 32'h10; dsp_seq = 81;
        tick("R11");
        look(32'h64, "R11");

        // R10: everything empty after clear
        look(32'h14, "R10");
        look(32'h2C, "R10");
        // R10: counters survive; retrain sets 5 and 13 and merge them
        train(32'h10, 32'h14, "R10");
        train(32'h30, 32'h34, "R10");
        train(32'h30, 32'h14, "R10");
        disp(32'h30, 90, 1, "R10");
        disp(32'h10, 91, 1, "R10");
        look(32'h14, "R10");
        look(32'h34, "R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule